// File: doc/BRIEF.md
# Digital CDS pixel accumulator

This block reads a CCD video stream as 16-bit ADC codes, one per clock, and returns one signed value per pixel. Inside each pixel period two programmable windows are marked: the reset (reference) window and the video (signal) window. A single accumulator adds every reference-window code and subtracts every signal-window code. All other codes are discarded. These include the clamp stretch at the head of the pixel and the settling stretch after charge transfer. At the last sample of the pixel the difference is handed to a serial divider. The divider scales it by the signal-window sample count while the next pixel's clamp interval runs. The result goes out as a one-cycle valid pulse with a 16-bit value, for a DMA writer.

A row begins when the row enable rises. At that moment the pixel length and the window starts and lengths are captured, and they stay fixed for the whole row. Dropping the row enable abandons the pixel in progress. If the captured window set cannot be sequenced safely, the row produces nothing.

Top module: `cds_pixel_accum`

## Requirements
- R1: Every code taken at a pixel position p with ref_start <= p < ref_start+ref_len is added to the pixel's sum. Position 0 is the first sample after row start or after the previous pixel's last sample.
- R2: Every code taken at a position p with sig_start <= p < sig_start+sig_len is subtracted from the same sum.
- R3: Codes at positions that lie in neither window have no effect on the output value.
- R4: The output is the sum divided by sig_len, truncated toward zero, as two's-complement.
- R5: A quotient above 32767 is output as 32767. A quotient below -32768 is output as -32768.
- R6: pix_valid is high for exactly one cycle per completed pixel. The edge that produces it is the 30th clock edge after the edge that absorbs the pixel's last sample.
- R7: Row enable high in idle starts a row. Row enable low during a row abandons the unfinished pixel with no output and returns to idle. A pixel already completed is still delivered.
- R8: pix_len and the window inputs are captured on the edge that starts the row. Later changes during that row have no effect.
- R9: A row produces no output if any of these holds: sig_len is 0; either window length exceeds 1024; either window ends past pix_len; pix_len is below 32; or the two windows share a position.
- R10: The sum restarts from zero at every pixel, including the first pixel after an abandoned row.
- R11: While reset is asserted, and until a row completes a pixel, pix_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en | input | 1 | High for the duration of a CCD row |
| adc_code | input | 16 | Unsigned ADC sample, one per clock |
| pix_len | input | 12 | Samples per pixel |
| ref_start | input | 12 | First position of the reference window |
| ref_len | input | 12 | Reference window length |
| sig_start | input | 12 | First position of the signal window |
| sig_len | input | 12 | Signal window length, also the divisor |
| pix_valid | output | 1 | One-cycle strobe for a finished pixel |
| pix_value | output | 16 | Signed pixel value |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A window counter that is off by one position pulls a junk code (65535) into the sum. The very next pixel value is then visibly wrong.
- A sum that is not cleared between pixels shows up as a doubled value on the second pixel of a row.
- A sum that is not cleared after an abandoned row spoils the first pixel of the following row.
- A divider that is slow, or whose step counter is wrong, moves the valid strobe off the 30-edge mark. This is detected on the first pixel.
- A sign or saturation fault appears only for negative or out-of-range quotients. These are driven on purpose, including the exact -32768 case.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cds_window_seq.sv
module cds_window_seq
  import cds_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_SMP = 1024,
  parameter int MIN_PIX = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_en,
  input  logic [LEN_W-1:0] pix_len,
  input  logic [LEN_W-1:0] ref_start,
  input  logic [LEN_W-1:0] ref_len,
  input  logic [LEN_W-1:0] sig_start,
  input  logic [LEN_W-1:0] sig_len,
  output logic             run,
  output logic             in_ref,
  output logic             in_sig,
  output logic             pix_first,
  output logic             pix_end,
  output logic [LEN_W-1:0] sig_cnt
);
  localparam logic [LEN_W:0] MAX_L = (LEN_W+1)'(MAX_SMP);
  localparam logic [LEN_W:0] MIN_L = (LEN_W+1)'(MIN_PIX);

  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] pl_q, rs_q, ss_q, sl_q;
  logic [LEN_W:0]   re_q, se_q;
  logic             load;

  logic [LEN_W:0] ref_end_in, sig_end_in;
  logic           overlap_in, cfg_ok;

  assign ref_end_in = {1'b0, ref_start} + {1'b0, ref_len};
  assign sig_end_in = {1'b0, sig_start} + {1'b0, sig_len};
  assign overlap_in = (ref_len != '0) &&
                      ({1'b0, sig_start} < ref_end_in) &&
                      ({1'b0, ref_start} < sig_end_in);
  assign cfg_ok = (sig_len != '0) &&
                  ({1'b0, sig_len} <= MAX_L) &&
                  ({1'b0, ref_len} <= MAX_L) &&
                  (ref_end_in <= {1'b0, pix_len}) &&
                  (sig_end_in <= {1'b0, pix_len}) &&
                  ({1'b0, pix_len} >= MIN_L) &&
                  !overlap_in;

  logic last;
  assign run       = (state_q == SEQ_RUN) && row_en;
  assign last      = (pos_q == pl_q - 1'b1);
  assign pix_first = run && (pos_q == '0);
  assign pix_end   = run && last;
  assign in_ref    = run && (pos_q >= rs_q) && ({1'b0, pos_q} < re_q);
  assign in_sig    = run && (pos_q >= ss_q) && ({1'b0, pos_q} < se_q);
  assign sig_cnt   = sl_q;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    load    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (row_en) begin
          load    = 1'b1;
          pos_d   = '0;
          state_d = cfg_ok ? SEQ_RUN : SEQ_HOLD;
        end
      end
      SEQ_RUN: begin
        if (!row_en) state_d = SEQ_IDLE;
        else         pos_d   = last ? '0 : pos_q + 1'b1;
      end
      SEQ_HOLD: begin
        if (!row_en) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_q <= '0;
      rs_q <= '0;
      ss_q <= '0;
      sl_q <= '0;
      re_q <= '0;
      se_q <= '0;
    end else if (load) begin
      pl_q <= pix_len;
      rs_q <= ref_start;
      ss_q <= sig_start;
      sl_q <= sig_len;
      re_q <= ref_end_in;
      se_q <= sig_end_in;
    end
  end

  // R9
  win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ref, in_sig}));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN) |=> ((state_q != SEQ_RUN) ||
      ($stable(pl_q) && $stable(sl_q) && $stable(re_q) && $stable(se_q))));
endmodule

// File: rtl/cds_accum.sv
module cds_accum #(
  parameter int SMP_W   = 16,
  parameter int ACC_W   = 27,
  parameter int MAX_SMP = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic                    add,
  input  logic                    sub,
  input  logic [SMP_W-1:0]        smp,
  output logic signed [ACC_W-1:0] acc_nx
);
  logic signed [ACC_W-1:0] acc_q, base, smp_x;

  assign smp_x  = $signed({{(ACC_W-SMP_W){1'b0}}, smp});
  assign base   = first ? '0 : acc_q;
  assign acc_nx = add ? (base + smp_x) : (sub ? (base - smp_x) : base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_nx;
  end

  localparam longint BOUND = longint'(MAX_SMP) * ((longint'(1) << SMP_W) - 1);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((longint'(acc_nx) <= BOUND) && (longint'(acc_nx) >= -BOUND)));
endmodule

// File: rtl/cds_div.sv
module cds_div #(
  parameter int ACC_W   = 27,
  parameter int DIV_W   = 12,
  parameter int OUT_W   = 16,
  parameter int LATENCY = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] dividend,
  input  logic [DIV_W-1:0]        divisor,
  output logic                    valid,
  output logic signed [OUT_W-1:0] data
);
  localparam int STEP_W = $clog2(LATENCY);
  localparam logic [ACC_W-1:0] POS_LIM = ACC_W'((64'd1 << (OUT_W-1)) - 1);
  localparam logic [ACC_W-1:0] NEG_LIM = ACC_W'(64'd1 << (OUT_W-1));
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [ACC_W-1:0]  q_q, q_d;
  logic [DIV_W-1:0]  r_q, r_d, d_q, d_d;
  logic              neg_q, neg_d;
  logic              vld_q, vld_d;
  logic [OUT_W-1:0]  dat_q, dat_d;

  logic [ACC_W-1:0] mag;
  logic [DIV_W:0]   trial;
  logic [OUT_W-1:0] sat;

  assign mag   = dividend[ACC_W-1] ? ACC_W'(-dividend) : ACC_W'(dividend);
  assign trial = {r_q, q_q[ACC_W-1]};

  always_comb begin
    if (neg_q) sat = (q_q > NEG_LIM) ? OUT_MIN : OUT_W'(-q_q[OUT_W-1:0]);
    else       sat = (q_q > POS_LIM) ? OUT_MAX : q_q[OUT_W-1:0];
  end

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    q_d    = q_q;
    r_d    = r_q;
    d_d    = d_q;
    neg_d  = neg_q;
    vld_d  = 1'b0;
    dat_d  = dat_q;
    if (start) begin
      busy_d = 1'b1;
      step_d = '0;
      q_d    = mag;
      r_d    = '0;
      d_d    = divisor;
      neg_d  = dividend[ACC_W-1];
    end else if (busy_q) begin
      step_d = step_q + 1'b1;
      if (int'(step_q) < ACC_W) begin
        if (trial >= {1'b0, d_q}) begin
          r_d = DIV_W'(trial - {1'b0, d_q});
          q_d = {q_q[ACC_W-2:0], 1'b1};
        end else begin
          r_d = trial[DIV_W-1:0];
          q_d = {q_q[ACC_W-2:0], 1'b0};
        end
      end
      if (step_q == STEP_W'(LATENCY-1)) begin
        busy_d = 1'b0;
        vld_d  = 1'b1;
        dat_d  = sat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      neg_q  <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      q_q    <= q_d;
      r_q    <= r_d;
      d_q    <= d_d;
      neg_q  <= neg_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
    end
  end

  assign valid = vld_q;
  assign data  = $signed(dat_q);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && !vld_q));
endmodule

// File: rtl/cds_pixel_accum.sv
module cds_pixel_accum #(
  parameter int SMP_W   = 16,
  parameter int LEN_W   = 12,
  parameter int MAX_SMP = 1024,
  parameter int OUT_W   = 16,
  parameter int LATENCY = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_en,
  input  logic [SMP_W-1:0]  adc_code,
  input  logic [LEN_W-1:0]  pix_len,
  input  logic [LEN_W-1:0]  ref_start,
  input  logic [LEN_W-1:0]  ref_len,
  input  logic [LEN_W-1:0]  sig_start,
  input  logic [LEN_W-1:0]  sig_len,
  output logic              pix_valid,
  output logic [OUT_W-1:0]  pix_value
);
  localparam int ACC_W   = SMP_W + $clog2(MAX_SMP) + 1;
  localparam int MIN_PIX = LATENCY + 2;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic                    run, in_ref, in_sig, pix_first, pix_end;
  logic [LEN_W-1:0]        sig_cnt;
  logic signed [ACC_W-1:0] acc_nx;
  logic signed [OUT_W-1:0] q_out;

  cds_window_seq #(
    .LEN_W  (LEN_W),
    .MAX_SMP(MAX_SMP),
    .MIN_PIX(MIN_PIX)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .row_en   (row_en),
    .pix_len  (pix_len),
    .ref_start(ref_start),
    .ref_len  (ref_len),
    .sig_start(sig_start),
    .sig_len  (sig_len),
    .run      (run),
    .in_ref   (in_ref),
    .in_sig   (in_sig),
    .pix_first(pix_first),
    .pix_end  (pix_end),
    .sig_cnt  (sig_cnt)
  );

  cds_accum #(
    .SMP_W  (SMP_W),
    .ACC_W  (ACC_W),
    .MAX_SMP(MAX_SMP)
  ) u_acc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (run),
    .first (pix_first),
    .add   (in_ref),
    .sub   (in_sig),
    .smp   (adc_code),
    .acc_nx(acc_nx)
  );

  cds_div #(
    .ACC_W  (ACC_W),
    .DIV_W  (LEN_W),
    .OUT_W  (OUT_W),
    .LATENCY(LATENCY)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (pix_end),
    .dividend(acc_nx),
    .divisor (sig_cnt),
    .valid   (pix_valid),
    .data    (q_out)
  );

  assign pix_value = q_out;
endmodule

// File: tb/sim_cds_pixel_accum.sv
module sim_cds_pixel_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_en = 1'b0;
  logic [15:0] adc_code = '0;
  logic [11:0] pix_len = '0, ref_start = '0, ref_len = '0, sig_start = '0, sig_len = '0;
  logic        pix_valid;
  logic [15:0] pix_value;

  always #5ns clk = ~clk;

  cds_pixel_accum u0 (
    .clk(clk), .rst_n(rst_n), .row_en(row_en), .adc_code(adc_code),
    .pix_len(pix_len), .ref_start(ref_start), .ref_len(ref_len),
    .sig_start(sig_start), .sig_len(sig_len),
    .pix_valid(pix_valid), .pix_value(pix_value)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, n_out = 0;
  int exp_v = 0;
  int exp_q[$];
  bit prev_v = 1'b0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // columns: pix_len, ref_start, ref_len, sig_start, sig_len, ref_lvl, sig_lvl, expected value, pixels, expected outputs
  localparam int NV = 16;
  localparam int VEC [NV][10] = '{
    '{  40,  4,    8,   20,    8,  1000,   600,    400, 2, 2},  // R1 R2 R3
    '{  48,  4,    4,   24,    8,  2000,   500,    500, 2, 2},  // R4 unequal counts
    '{  40,  4,    8,   20,    8,   100,   300,   -200, 2, 2},  // R4 negative
    '{  40,  4,    3,   20,    2,     1,     0,      1, 2, 2},  // R4 truncation, positive
    '{  40,  4,    3,   20,    2,     1,     3,     -1, 2, 2},  // R4 truncation toward zero, negative
    '{  64,  2,   20,   40,    1, 65535,     0,  32767, 2, 2},  // R5 high clip
    '{  64,  2,    1,   40,    1,     0, 65535, -32768, 2, 2},  // R5 low clip
    '{  64,  2,    1,   40,    1,     0, 32768, -32768, 2, 2},  // R5 exact minimum
    '{  40,  4,    8,   20,    0,  1000,   600,      0, 2, 0},  // R9 zero signal length
    '{  40,  4,   10,   10,    4,     1,     1,      0, 2, 0},  // R9 overlap
    '{  40,  4,    6,   10,    4,    10,     5,     10, 2, 2},  // R9 adjacent windows accepted
    '{  40,  4,    8,   36,    8,     1,     1,      0, 2, 0},  // R9 window past pixel end
    '{  20,  2,    4,   10,    4,     1,     1,      0, 2, 0},  // R9 short pixel
    '{2070, 10, 1024, 1040, 1024, 40000, 10000,  30000, 2, 2},  // R1 R2 full-length windows
    '{  40, 20,    8,    4,    8,  1000,   600,    400, 2, 2},  // R3 signal window first
    '{2200,  4, 1025, 1100,    8,     1,     1,      0, 1, 0}   // R9 window too long
  };

  function automatic int code_at(int p, int rs, int rl, int ss, int sl, int rf, int sg);
    if (p >= rs && p < rs + rl) return rf;
    if (p >= ss && p < ss + sl) return sg;
    return 65535;  // junk outside windows, R3
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (pix_valid) begin
        n_out++;
        chk(!prev_v, "R6 valid wider than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected output", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R6 output cycle", cyc, e);
          chk($signed(pix_value) == exp_v, "R4 pixel value", $signed(pix_value), exp_v);
        end
      end
      prev_v = pix_valid;
    end
  end

  task automatic run_row(int pl, int rs, int rl, int ss, int sl, int rf, int sg,
                         int ev, int npix, int ecnt, int cut, bit scramble, string tag);
    bit stop;
    @(negedge clk);
    pix_len = 12'(pl); ref_start = 12'(rs); ref_len = 12'(rl);
    sig_start = 12'(ss); sig_len = 12'(sl);
    row_en = 1'b1;
    exp_v = ev;
    n_out = 0;
    @(negedge clk);
    if (scramble) begin  // R8: change inputs after the row has started
      sig_len = 12'd0; pix_len = 12'd33; ref_start = 12'd0; sig_start = 12'd1;
    end
    stop = 1'b0;
    for (int pix = 0; pix < npix && !stop; pix++) begin
      for (int p = 0; p < pl && !stop; p++) begin
        if (pix == npix - 1 && p == cut) begin
          stop = 1'b1;
        end else begin
          adc_code = 16'(code_at(p, rs, rl, ss, sl, rf, sg));
          if (p == pl - 1 && ecnt != 0) exp_q.push_back(cyc + 31);
          @(negedge clk);
        end
      end
    end
    row_en = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_out == ecnt, tag, n_out, ecnt);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R11 valid during reset", pix_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pix_valid == 1'b0, "R11 valid after reset", pix_valid, 0);
    mon_on = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_row(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
              VEC[v][6], VEC[v][7], VEC[v][8], VEC[v][9], -1, 1'b0, "R9 output count");
    end

    // R7: drop row enable halfway through the second pixel
    run_row(40, 4, 8, 20, 8, 1000, 600, 400, 2, 1, 25, 1'b0, "R7 abandoned pixel");
    // R10: next row after an abandoned pixel starts from a clean sum
    run_row(40, 4, 8, 20, 8, 1000, 600, 400, 2, 2, -1, 1'b0, "R10 clean sum");
    // R7: abandon during the very first pixel, nothing delivered
    run_row(40, 4, 8, 20, 8, 1000, 600, 400, 1, 0, 30, 1'b0, "R7 no output");
    // R8: settings changed mid-row are ignored
    run_row(40, 4, 8, 20, 8, 1000, 600, 400, 2, 2, -1, 1'b1, "R8 latched settings");

    chk(pix_valid == 1'b0, "R11 idle output", pix_valid, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule